// File: doc/BRIEF.md
# Sequential Booth-Recoded Signed Multiplier

This block multiplies two N-bit two's-complement operands over N clock cycles and returns a 2N-bit signed product. It does not add the multiplicand once for every set bit of the multiplier. Instead it scans the multiplier from the least significant end and acts only where a run of ones begins or ends.

At the low edge of a run it subtracts the multiplicand, and one position above the run's high edge it adds it back. This works because a run of ones spanning weights 2^j through 2^i is worth 2^(i+1) − 2^j. The same recoding folds the sign-extension ones of a negative multiplier into one negative weight, so no sign fix-up step is needed at the end.

A one-cycle `start` pulse loads both operands. A `start` that arrives while an operation is in progress is ignored. After exactly N shift steps, `done` pulses high for one cycle. The `product` register is updated on that same edge and then holds its value until the next operation completes. The accumulator has one guard bit, so the most negative multiplicand is handled correctly.

Top module: `booth_seq_mul`

## Requirements
- R1: While reset is active and right after it is released, `product` reads 0 and `done` reads 0.
- R2: For any pair of signed N-bit operands, the product reported with `done` equals the exact two's-complement product, sign-extended to 2N bits.
- R3: The most negative value (−2^(N−1)) gives a correct product both as multiplicand and as multiplier, including the case where both operands take it (16384 at N=8).
- R4: `done` rises on the N-th rising edge after the edge that samples an accepted `start`, and it stays high for exactly one cycle.
- R5: `product` changes only on the edge that raises `done`. In every other cycle it keeps its previous value.
- R6: A `start` pulse seen while an operation is running is ignored: the running operation's result and timing are unaffected.
- R7: Multipliers made of runs of ones give correct products. Examples are 8'b00011110 (M×30), 8'b01111010 (M×122) and a multiplier with a single isolated 1 bit.
- R8: Within one operation, the non-idle steps strictly alternate. The first is a subtraction (bit pair current=1, previous=0) and the next is an addition (current=0, previous=1), and so on.
- R9: Negative multipliers, including −1 (all ones), give the correct signed product with no correction step.
- R10: A zero operand on either side gives a zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| mcand | input | N | Signed multiplicand |
| mplier | input | N | Signed multiplier |
| product | output | 2N | Signed product of the last finished operation |
| done | output | 1 | One-cycle pulse when `product` updates |

## Verification
The assertions check four things on every cycle. `done` is a single-cycle pulse, `product` holds still whenever `done` is low, the add and subtract steps strictly alternate and begin with a subtract, and a `start` during a run leaves the latched multiplicand untouched. Only the bench's scenarios can show that the numeric products are right across sign combinations, run patterns and the most negative operand. They also show that `done` lands exactly N edges after acceptance, and that a mid-run start leaves the result unchanged.

// File: rtl/booth_seq_mul.sv
module booth_seq_mul #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic [2*N-1:0] product,
  output logic           done
);
  localparam int CW = $clog2(N + 1);

  logic [N:0]    acc, mc, sum, acc_n;
  logic [N-1:0]  q, q_n;
  logic          qm1, busy, last;
  logic [1:0]    pair;
  logic [CW-1:0] cnt;

  assign pair = {q[0], qm1};

  always_comb begin
    case (pair)
      2'b10:   sum = acc - mc;
      2'b01:   sum = acc + mc;
      default: sum = acc;
    endcase
  end

  assign acc_n = {sum[N], sum[N:1]};
  assign q_n   = {sum[0], q[N-1:1]};
  assign last  = (cnt == CW'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      mc      <= '0;
      q       <= '0;
      qm1     <= 1'b0;
      cnt     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      product <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        acc <= acc_n;
        q   <= q_n;
        qm1 <= q[0];
        cnt <= cnt + 1'b1;
        if (last) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          product <= {acc_n[N-1:0], q_n};
        end
      end else if (start) begin
        acc  <= '0;
        q    <= mplier;
        qm1  <= 1'b0;
        mc   <= {mcand[N-1], mcand};
        cnt  <= '0;
        busy <= 1'b1;
      end
    end
  end

  logic owe_add;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  owe_add <= 1'b0;
    else if (!busy && start)     owe_add <= 1'b0;
    else if (busy && pair == 2'b10) owe_add <= 1'b1;
    else if (busy && pair == 2'b01) owe_add <= 1'b0;
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));

  // R8
  sub_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pair == 2'b10) |-> !owe_add);

  // R8
  add_after_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pair == 2'b01) |-> owe_add);

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mc));

endmodule

// File: tb/booth_seq_mul_tb_top.sv
module booth_seq_mul_tb_top;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N-1:0]   mcand = '0, mplier = '0;
  logic [2*N-1:0] product;
  logic           done;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  booth_seq_mul #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
    .mplier(mplier), .product(product), .done(done)
  );

  function automatic logic [2*N-1:0] ref_mul(logic [N-1:0] a, logic [N-1:0] b);
    logic signed [2*N-1:0] sa, sb;
    sa = $signed({{N{a[N-1]}}, a});
    sb = $signed({{N{b[N-1]}}, b});
    return sa * sb;
  endfunction

  task automatic check(string req, logic [2*N-1:0] act, logic [2*N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inject: cycle index at which a stray start with other operands is pulsed (-1 none)
  task automatic run(string req, logic [N-1:0] a, logic [N-1:0] b, int inject);
    logic [2*N-1:0] prev;
    int cyc;
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    mcand = ~a; mplier = ~b;
    cyc = 0;
    prev = product;
    while (!done && cyc < 4 * N) begin
      if (product !== prev) check("R5", product, prev);
      start = (cyc == inject);
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    check({req, " product"}, product, ref_mul(a, b));
    check("R4 latency", 16'(cyc), 16'(N));
    prev = product;
    @(negedge clk);
    check("R4 pulse width", {15'd0, done}, 16'd0);
    check("R5 hold", product, prev);
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1
    check("R1 product", product, '0);
    check("R1 done", {15'd0, done}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", product, '0);

    run("R7 run 00011110", 8'd37, 8'b00011110, -1);
    run("R7 runs 01111010", 8'hE9, 8'b01111010, -1);
    run("R7 single one", 8'd91, 8'b00010000, -1);
    run("R9 mplier -1", 8'd55, 8'hFF, -1);
    run("R9 neg mplier", 8'hC3, 8'h9A, -1);
    run("R3 min mcand", 8'h80, 8'd3, -1);
    run("R3 min mplier", 8'd100, 8'h80, -1);
    run("R3 min both", 8'h80, 8'h80, -1);
    run("R3 min times -1", 8'h80, 8'hFF, -1);
    run("R10 zero mplier", 8'h7F, 8'h00, -1);
    run("R10 zero mcand", 8'h00, 8'hA5, -1);
    run("R2 max", 8'h7F, 8'h7F, -1);
    run("R6 stray start", 8'd45, 8'hD7, 2);
    run("R6 stray start late", 8'hF1, 8'd77, N - 1);

    for (int i = 0; i < 300; i++) begin
      run("R2 random", N'($urandom), N'($urandom), (i % 7 == 0) ? i % N : -1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule